// File: doc/BRIEF.md
# Processor I/O Port with Decaying Floating Bits

This block is an 8-bit I/O port built into a processor and mapped at the two lowest addresses of its memory space. Address 0 holds a direction register, where a 1 marks a bit as an output. Address 1 holds an output-data register. Every other address is forwarded without change to an external RAM interface. The port keeps a model of its pin levels. It drives a 3-bit bank-select output, which is taken from the low three bits of the port.

Bits 6 and 7 have no physical pin. When one of them is set to input, a read returns a charge that the bit stored while it was last an output. That charge drains to zero a programmable number of cycles after it was stored. Each of the two bits has its own timer. The timer compares a stored expiry cycle with a free-running cycle count, and the decay is applied when address 1 is read. Writes to the two port addresses also reach the RAM at the same address. The RAM receives the last byte seen on the data bus, not the byte the processor wrote.

Top module: `cpu_port_decay`

## Requirements
- R1: After reset, address 0 reads 0x00, address 1 reads 0x1F, `port_pins` is 0x3F and `bank_sel` is 7.
- R2: A write to address 0 sets the direction register, and a later read of address 0 returns it unchanged. A write to address 1 sets the data register.
- R3: In the cycle after any register write, each pin bit whose direction is 1 equals the data bit, and each pin bit whose direction is 0 keeps its previous level.
- R4: A read of address 1 returns `(data | ~dir) & (pins | 0x17)`. Bit 5 of that value is forced to 0 while direction bit 5 is 0. Bits 6 and 7 come from this value while their direction is 1.
- R5: From the cycle after a register write, `bank_sel` equals `(data | ~dir) & 3'b111`.
- R6: When direction bit 6 or 7 is written from 1 to 0, that bit stores the current data-register bit. While the bit stays an input, reads of address 1 return the stored bit in that position. A data write to a bit whose direction is 1 also stores the written bit and restarts its timer.
- R7: The timer is armed in cycle c, the cycle of the write that arms it. A read in cycle c+DECAY_CYCLES still returns the stored bit. A read in cycle c+DECAY_CYCLES+1 or later returns 0 in that position.
- R8: Bits 6 and 7 have separate timers. Arming one timer does not move the expiry of the other.
- R9: A write to address 1 leaves the stored value of bit 6 or 7 unchanged while that bit's direction is 0.
- R10: An access to an address of 2 or more drives `ram_addr`, `ram_wdata`, `ram_wr` and `ram_rd` from the access itself, and a read returns `ram_rdata`. Accesses to addresses 0 and 1 keep `ram_rd` low.
- R11: A write to address 0 or 1 also asserts `ram_wr` at the same address, with `ram_wdata` equal to `bus_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the same cycle as the strobe |
| bus_last | input | 8 | Last byte seen on the data bus |
| bank_sel | output | 3 | Bank-select lines |
| port_pins | output | 8 | Modelled pin levels |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
A wrong direction or data register shows up in the very next cycle on `bank_sel` and `port_pins`. A stray pin update shows up the same way. A stored bit or expiry value that is wrong stays hidden until two conditions hold: the bit has been switched to input, and address 1 is read. An expiry that is off by one cycle is only visible in a read placed exactly at the edge of the decay period. The tests therefore read the port in both the last cycle that must return the stored bit and the first cycle that must return 0, for each bit and with the two timers offset from each other.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
    localparam int PORT_W = 8;
    localparam int BANK_W = 3;
    localparam int FLOAT_LO = 6;
    localparam int FLOAT_N = 2;
    localparam int GATED_BIT = 5;
    localparam logic [PORT_W-1:0] PULLUP_MASK = 8'h17;
    localparam logic [PORT_W-1:0] RESET_DATA = 8'h3F;
    localparam logic [PORT_W-1:0] RESET_PINS = 8'h3F;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] pins;
    } port_regs_t;
endpackage

// File: rtl/cpu_port_timebase.sv
module cpu_port_timebase #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now
);
    logic [TIME_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + TIME_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign now = cnt_q;

    // R7: the time reference advances by exactly one per cycle
    a_r7_time_steps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_q == $past(cnt_q) + TIME_W'(1)));
endmodule

// File: rtl/cpu_port_decay_cell.sv
module cpu_port_decay_cell #(
    parameter int TIME_W = 32,
    parameter int PERIOD = 350000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              dir_cur,
    input  logic              dir_wr,
    input  logic              dir_new,
    input  logic              data_wr,
    input  logic              data_new,
    input  logic              data_cur,
    input  logic              rd_evt,
    output logic              held_out
);
    localparam logic [TIME_W-1:0] SPAN = TIME_W'(PERIOD);

    typedef struct packed {
        logic              held;
        logic              armed;
        logic [TIME_W-1:0] expiry;
    } cell_t;

    cell_t s_d, s_q;
    logic  expired;

    always_comb begin
        expired = s_q.armed && (s_q.expiry < now);
        s_d = s_q;
        if (data_wr && dir_cur) begin
            s_d.held   = data_new;
            s_d.armed  = 1'b1;
            s_d.expiry = now + SPAN;
        end else if (dir_wr && dir_cur && !dir_new) begin
            s_d.held   = data_cur;
            s_d.armed  = 1'b1;
            s_d.expiry = now + SPAN;
        end else if (rd_evt && expired) begin
            s_d.held  = 1'b0;
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign held_out = expired ? 1'b0 : s_q.held;

    // R7: a timer is disarmed only once its expiry lies before the current cycle
    a_r7_disarm_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.armed) |-> ($past(s_q.expiry) < $past(now)));

    // R9: a data write to an input bit leaves the stored charge alone
    a_r9_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !dir_cur && !rd_evt) |=> $stable(s_q.held));
endmodule

// File: rtl/cpu_port_decay.sv
module cpu_port_decay
    import cpu_port_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int TIME_W       = 32,
    parameter int DECAY_CYCLES = 350000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    input  logic [7:0]        bus_last,
    output logic [2:0]        bank_sel,
    output logic [7:0]        port_pins,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1);

    port_regs_t        r_d, r_q;
    logic              sel_dir, sel_data, sel_port;
    logic              dir_wr, data_wr, port_rd;
    logic [PORT_W-1:0] drive_lvl, base_val, read_val;
    logic [TIME_W-1:0] now;
    logic [FLOAT_N-1:0] held;

    assign sel_dir  = (acc_addr == DIR_ADDR);
    assign sel_data = (acc_addr == DATA_ADDR);
    assign sel_port = sel_dir || sel_data;
    assign dir_wr   = acc_wr && sel_dir;
    assign data_wr  = acc_wr && sel_data;
    assign port_rd  = acc_rd && sel_data;

    always_comb begin
        r_d = r_q;
        if (dir_wr)  r_d.dir  = acc_wdata;
        if (data_wr) r_d.data = acc_wdata;
        r_d.pins = (r_q.pins & ~r_d.dir) | (r_d.data & r_d.dir);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.dir  <= '0;
            r_q.data <= RESET_DATA;
            r_q.pins <= RESET_PINS;
        end else begin
            r_q <= r_d;
        end
    end

    cpu_port_timebase #(.TIME_W(TIME_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    for (genvar g = 0; g < FLOAT_N; g++) begin : g_float
        localparam int IDX = FLOAT_LO + g;
        cpu_port_decay_cell #(.TIME_W(TIME_W), .PERIOD(DECAY_CYCLES)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .now      (now),
            .dir_cur  (r_q.dir[IDX]),
            .dir_wr   (dir_wr),
            .dir_new  (acc_wdata[IDX]),
            .data_wr  (data_wr),
            .data_new (acc_wdata[IDX]),
            .data_cur (r_q.data[IDX]),
            .rd_evt   (port_rd),
            .held_out (held[g])
        );
    end

    always_comb begin
        drive_lvl = r_q.data | ~r_q.dir;
        base_val  = drive_lvl & (r_q.pins | PULLUP_MASK);
        if (!r_q.dir[GATED_BIT]) base_val[GATED_BIT] = 1'b0;
        read_val = base_val;
        for (int i = 0; i < FLOAT_N; i++) begin
            if (!r_q.dir[FLOAT_LO + i]) read_val[FLOAT_LO + i] = held[i];
        end
    end

    always_comb begin
        if (sel_dir)       acc_rdata = r_q.dir;
        else if (sel_data) acc_rdata = read_val;
        else               acc_rdata = ram_rdata;
    end

    assign bank_sel  = drive_lvl[BANK_W-1:0];
    assign port_pins = r_q.pins;
    assign ram_addr  = acc_addr;
    assign ram_rd    = acc_rd && !sel_port;
    assign ram_wr    = acc_wr;
    assign ram_wdata = sel_port ? bus_last : acc_wdata;

    // R2: a direction write is visible in the register one cycle later
    a_r2_dir_lands: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (r_q.dir == $past(acc_wdata)));

    // R2: a data write is visible in the register one cycle later
    a_r2_data_lands: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (r_q.data == $past(acc_wdata)));

    // R3: output pins always agree with the data register
    a_r3_outputs_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (((r_q.pins ^ r_q.data) & r_q.dir) == '0));

    // R3: input pins never change level
    a_r3_inputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((r_q.pins ^ $past(r_q.pins)) & ~r_q.dir) == '0));
endmodule

// File: tb/cpu_port_decay_bench.sv
`timescale 1ns/1ps
module cpu_port_decay_bench;
    localparam int P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_rd = 1'b0, acc_wr = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic [7:0]  bus_last = 8'hE7;
    logic [2:0]  bank_sel;
    logic [7:0]  port_pins;
    logic        ram_rd, ram_wr;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;

    int checks = 0;
    int fails  = 0;

    logic [7:0] dir_m, data_m, pins_m;
    logic       seen_wr, seen_rd;
    logic [7:0] seen_wdata;
    logic [15:0] seen_addr;

    always #2.5 clk = ~clk;

    assign ram_rdata = ram_addr[7:0] ^ ram_addr[15:8] ^ 8'h5C;

    cpu_port_decay #(.ADDR_W(16), .TIME_W(32), .DECAY_CYCLES(P)) u_cpu_port_decay (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .bus_last(bus_last), .bank_sel(bank_sel), .port_pins(port_pins),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_port(input logic h6, input logic h7);
        logic [7:0] v;
        v = (data_m | ~dir_m) & (pins_m | 8'h17);
        if (!dir_m[5]) v[5] = 1'b0;
        if (!dir_m[6]) v[6] = h6;
        if (!dir_m[7]) v[7] = h7;
        return v;
    endfunction

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        #1;
        seen_wr = ram_wr; seen_wdata = ram_wdata; seen_addr = ram_addr;
        @(posedge clk);
        if (a == 16'd0) dir_m = d;
        if (a == 16'd1) data_m = d;
        pins_m = (pins_m & ~dir_m) | (data_m & dir_m);
        #1;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        acc_rd = 1'b1; acc_wr = 1'b0; acc_addr = a;
        #1;
        v = acc_rdata; seen_rd = ram_rd; seen_addr = ram_addr;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_rd = 1'b0; acc_wr = 1'b0;
            @(posedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 pins", {8'h0, port_pins}, 16'h3F);
        chk("R1 bank", {13'h0, bank_sel}, 16'h7);
        do_rd(16'd0, v); chk("R1 dir read", {8'h0, v}, 16'h00);
        do_rd(16'd1, v); chk("R1 port read", {8'h0, v}, 16'h1F);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        do_wr(16'd0, 8'hC5); do_rd(16'd0, v); chk("R2 dir readback", {8'h0, v}, 16'hC5);
        do_wr(16'd1, 8'h9A);
        chk("R3 pins after data", {8'h0, port_pins}, {8'h0, pins_m});
        chk("R5 bank C5/9A", {13'h0, bank_sel}, {13'h0, 3'((data_m | ~dir_m) & 8'h07)});
        do_rd(16'd1, v); chk("R4 port C5/9A", {8'h0, v}, {8'h0, exp_port(1'b0, 1'b0)});
        do_wr(16'd0, 8'hE0); do_wr(16'd1, 8'h20);
        do_rd(16'd1, v); chk("R4 bit5 driven", {8'h0, v}, {8'h0, exp_port(1'b0, 1'b0)});
        do_wr(16'd0, 8'hC0); do_wr(16'd1, 8'hFF);
        do_rd(16'd1, v); chk("R4 bit5 gated", {8'h0, v}, {8'h0, exp_port(1'b0, 1'b0)});
    endtask

    task automatic t_pins_bank();
        logic [7:0] v;
        do_wr(16'd1, 8'hC0); do_wr(16'd0, 8'hC8);
        chk("R3 bit3 driven low", {8'h0, port_pins}, {8'h0, pins_m});
        do_wr(16'd0, 8'hC0);
        chk("R3 bit3 kept low", {15'h0, port_pins[3]}, 16'h0);
        do_rd(16'd1, v); chk("R4 bit3 from pins", {8'h0, v}, {8'h0, exp_port(1'b0, 1'b0)});
        do_wr(16'd0, 8'hC7); do_wr(16'd1, 8'hC5);
        chk("R5 bank 5", {13'h0, bank_sel}, 16'h5);
        do_wr(16'd0, 8'hC2); do_wr(16'd1, 8'hC0);
        chk("R5 bank undriven", {13'h0, bank_sel}, 16'h5);
        do_wr(16'd0, 8'hC7); do_wr(16'd1, 8'hC2);
        chk("R5 bank 2", {13'h0, bank_sel}, 16'h2);
    endtask

    task automatic t_hold_ignore();
        logic [7:0] v;
        do_wr(16'd0, 8'hC0); do_wr(16'd1, 8'hC0); do_wr(16'd0, 8'h00);
        do_rd(16'd1, v); chk("R6 held bits", {8'h0, v}, {8'h0, exp_port(1'b1, 1'b1)});
        do_wr(16'd1, 8'h00);
        do_rd(16'd1, v); chk("R9 input write ignored", {8'h0, v}, {8'h0, exp_port(1'b1, 1'b1)});
        idle(P + 2);
    endtask

    task automatic t_decay_edge();
        logic [7:0] v;
        do_wr(16'd0, 8'hC0); do_wr(16'd1, 8'h80); do_wr(16'd0, 8'h00);
        idle(P - 1);
        do_rd(16'd1, v); chk("R7 last held cycle", {8'h0, v}, {8'h0, exp_port(1'b0, 1'b1)});
        do_rd(16'd1, v); chk("R7 first decayed cycle", {8'h0, v}, {8'h0, exp_port(1'b0, 1'b0)});
        do_wr(16'd0, 8'hC0); do_wr(16'd1, 8'h40); do_wr(16'd0, 8'h00);
        do_rd(16'd1, v); chk("R6 bit6 stored", {8'h0, v}, {8'h0, exp_port(1'b1, 1'b0)});
    endtask

    task automatic t_independent();
        logic [7:0] v;
        idle(P + 2);
        do_wr(16'd0, 8'hC0); do_wr(16'd1, 8'hC0);
        do_wr(16'd0, 8'h80);
        idle(9);
        do_wr(16'd0, 8'h00);
        idle(10);
        do_rd(16'd1, v); chk("R8 bit6 decayed bit7 held", {8'h0, v}, {8'h0, exp_port(1'b0, 1'b1)});
        idle(8);
        do_rd(16'd1, v); chk("R8 bit7 last held", {8'h0, v}, {8'h0, exp_port(1'b0, 1'b1)});
        do_rd(16'd1, v); chk("R8 bit7 decayed", {8'h0, v}, {8'h0, exp_port(1'b0, 1'b0)});
    endtask

    task automatic t_ram();
        logic [7:0] v;
        do_rd(16'h1234, v);
        chk("R10 ram read data", {8'h0, v}, {8'h0, 8'h34 ^ 8'h12 ^ 8'h5C});
        chk("R10 ram read strobe", {15'h0, seen_rd}, 16'h1);
        chk("R10 ram read addr", seen_addr, 16'h1234);
        do_rd(16'd0, v);
        chk("R10 no ram read on port", {15'h0, seen_rd}, 16'h0);
        do_wr(16'h0002, 8'h77);
        chk("R10 ram write strobe", {15'h0, seen_wr}, 16'h1);
        chk("R10 ram write data", {8'h0, seen_wdata}, 16'h77);
        bus_last = 8'hB4;
        do_wr(16'd1, 8'h3C);
        chk("R11 mirror strobe", {15'h0, seen_wr}, 16'h1);
        chk("R11 mirror data", {8'h0, seen_wdata}, 16'hB4);
        chk("R11 mirror addr", seen_addr, 16'h0001);
        do_wr(16'd0, 8'hFF);
        chk("R11 mirror dir write", {8'h0, seen_wdata}, 16'hB4);
    endtask

    initial begin
        dir_m = 8'h00; data_m = 8'h3F; pins_m = 8'h3F;
        fork
            begin
                idle(3);
                @(negedge clk) rst_n = 1'b1;
                t_reset();
                t_regs();
                t_pins_bank();
                t_hold_ignore();
                t_decay_edge();
                t_independent();
                t_ram();
                idle(2);
            end
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule